// File: doc/BRIEF.md
# Multicycle Instruction-Cycle Sequencer

This block steps a small word-addressed accumulator machine through its instruction cycle. It holds the program counter, the memory address and buffer registers, the instruction register and the accumulator, plus a zero and a carry flag. The block has one memory port. Every instruction first passes through a fetch subcycle. An optional indirect subcycle follows, and then an execute subcycle carries out the opcode.

Instruction words are 16 bits wide. The opcode sits in bits [15:12], the indirection flag in bit [11] and an 11-bit address field in bits [10:0]. When indirection is requested, the controller reads one extra word at the address field, and that word becomes the effective address used by execute. Instruction and data memory live outside the block. It is reached through a request/acknowledge port that tolerates any number of wait cycles.

Top module: `cyc_sequencer`

## Requirements
- R1: Each fetch copies PC into the address register. It then issues a read (`mem_we`=0) at that address, captures the word in the buffer register and then moves it into the instruction register.
- R2: PC advances by exactly one word during each fetch, including the fetch of a halt instruction.
- R3: A request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stable until a one-cycle `mem_ack`. Read data is taken in the acknowledge cycle.
- R4: If bit [11] is set and the opcode is not halt, one extra read is made at bits [10:0]. The low 11 bits of the returned word form the effective address. Otherwise bits [10:0] are the effective address.
- R5: Opcode 1 (load) sets AC to the word at the effective address, sets zero when that word is 0 and clears carry.
- R6: Opcode 2 (store) writes AC to the effective address. It is the only instruction that issues a write request.
- R7: Opcode 3 (add) sets AC to the low 16 bits of AC plus the word at the effective address. Carry takes sum bit 16, and zero is set when the 16-bit result is 0.
- R8: Opcode 4 (jump) loads PC with the effective address.
- R9: Opcode 5 (jump if zero) loads PC with the effective address only while zero is set; otherwise PC keeps its incremented value. Jumps, stores and halt leave the flags unchanged.
- R10: Opcodes 6 to 15 change neither AC, PC beyond its fetch increment, nor the flags.
- R11: Opcode 0 (halt) raises `halted`, after which no further memory request is made and PC stays fixed until reset.
- R12: Reset clears PC, AC, zero and carry. After release, the first request is a read at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_addr | output | 11 | Memory word address |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_ack | input | 1 | One-cycle access completion |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| halted | output | 1 | Controller parked after halt |
| acc_out | output | 16 | Accumulator value |
| pc_out | output | 11 | Program counter value |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The hardest paths to reach from the ports are the ones where an indirect word redirects a store or a jump. A wrong effective address there is only visible as a write at the wrong place or as an instruction that gets skipped. The stimulus programs contain indirect load, store and jump instructions, plus a placed store that only executes if a jump goes wrong. Every write is checked against a queue of expected writes. The memory model also varies its acknowledge delay from zero to two wait cycles, so the stability of requests is tested under stalls.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  localparam logic [3:0] OPC_HALT  = 4'd0;
  localparam logic [3:0] OPC_LOAD  = 4'd1;
  localparam logic [3:0] OPC_STORE = 4'd2;
  localparam logic [3:0] OPC_ADD   = 4'd3;
  localparam logic [3:0] OPC_JMP   = 4'd4;
  localparam logic [3:0] OPC_JZ    = 4'd5;

  typedef enum logic [3:0] {
    ST_FADDR,
    ST_FREAD,
    ST_LDIR,
    ST_DECODE,
    ST_IREAD,
    ST_IFIN,
    ST_EXEC,
    ST_EMEM,
    ST_HALT
  } cyc_state_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mar_from_mbr;
    logic mbr_load;
    logic ir_load;
    logic pc_inc;
    logic pc_jump;
    logic acc_load;
    logic acc_add;
  } cyc_ctl_t;

endpackage

// File: rtl/cyc_alu.sv
module cyc_alu #(
  parameter int WORD_W = 16
) (
  input  logic              op_add,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] result,
  output logic              carry,
  output logic              zero
);

  logic [WORD_W:0] sum;

  always_comb begin
    sum = {1'b0, acc} + {1'b0, operand};
    if (op_add) begin
      result = sum[WORD_W-1:0];
      carry  = sum[WORD_W];
    end else begin
      result = operand;
      carry  = 1'b0;
    end
    zero = (result == '0);
  end

endmodule

// File: rtl/cyc_datapath.sv
module cyc_datapath
  import cyc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_ctl_t          ctl,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [WORD_W-1:0] ir,
  output logic [WORD_W-1:0] acc,
  output logic              flag_z,
  output logic              flag_c
);

  logic [WORD_W-1:0] mbr;
  logic [ADDR_W-1:0] pc_d, mar_d;
  logic [WORD_W-1:0] acc_d;
  logic              pc_en, mar_en, flags_en;
  logic              alu_c, alu_z;

  cyc_alu #(.WORD_W(WORD_W)) u_alu (
    .op_add  (ctl.acc_add),
    .acc     (acc),
    .operand (rdata),
    .result  (acc_d),
    .carry   (alu_c),
    .zero    (alu_z)
  );

  always_comb begin
    pc_en = ctl.pc_inc | ctl.pc_jump;
    pc_d  = ctl.pc_jump ? mar : pc + ADDR_W'(1);
  end

  always_comb begin
    mar_en = ctl.mar_from_pc | ctl.mar_from_ir | ctl.mar_from_mbr;
    if (ctl.mar_from_pc)       mar_d = pc;
    else if (ctl.mar_from_ir)  mar_d = ir[ADDR_W-1:0];
    else                       mar_d = mbr[ADDR_W-1:0];
  end

  assign flags_en = ctl.acc_load | ctl.acc_add;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else if (pc_en) pc <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mar <= '0;
    else if (mar_en) mar <= mar_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mbr <= '0;
    else if (ctl.mbr_load) mbr <= rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir <= '0;
    else if (ctl.ir_load) ir <= mbr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else if (flags_en) begin
      acc    <= acc_d;
      flag_z <= alu_z;
      flag_c <= alu_c;
    end
  end

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_inc |=> pc == $past(pc) + ADDR_W'(1));

  p_jump_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_jump |=> pc == $past(mar));

  p_load_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.acc_load |=> !flag_c && (flag_z == (acc == '0)));

  p_add_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.acc_add |=> flag_z == (acc == '0));

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.acc_load || ctl.acc_add) |=> $stable(flag_z) && $stable(flag_c));

endmodule

// File: rtl/cyc_ctrl.sv
module cyc_ctrl
  import cyc_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  input  logic            indirect,
  input  logic            flag_z,
  input  logic            mem_ack,
  output cyc_ctl_t        ctl,
  output logic            mem_req,
  output logic            mem_we,
  output logic            halted
);

  cyc_state_e state, state_d;
  logic is_mem_op;

  always_comb begin
    is_mem_op = (opcode == OP_W'(OPC_LOAD)) || (opcode == OP_W'(OPC_STORE)) ||
                (opcode == OP_W'(OPC_ADD));
  end

  always_comb begin
    state_d = state;
    ctl     = '0;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    case (state)
      ST_FADDR: begin
        ctl.mar_from_pc = 1'b1;
        state_d         = ST_FREAD;
      end
      ST_FREAD: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          ctl.mbr_load = 1'b1;
          ctl.pc_inc   = 1'b1;
          state_d      = ST_LDIR;
        end
      end
      ST_LDIR: begin
        ctl.ir_load = 1'b1;
        state_d     = ST_DECODE;
      end
      ST_DECODE: begin
        if (opcode == OP_W'(OPC_HALT)) begin
          state_d = ST_HALT;
        end else begin
          ctl.mar_from_ir = 1'b1;
          state_d         = indirect ? ST_IREAD : ST_EXEC;
        end
      end
      ST_IREAD: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          ctl.mbr_load = 1'b1;
          state_d      = ST_IFIN;
        end
      end
      ST_IFIN: begin
        ctl.mar_from_mbr = 1'b1;
        state_d          = ST_EXEC;
      end
      ST_EXEC: begin
        if (is_mem_op) begin
          state_d = ST_EMEM;
        end else begin
          if (opcode == OP_W'(OPC_JMP))     ctl.pc_jump = 1'b1;
          else if (opcode == OP_W'(OPC_JZ)) ctl.pc_jump = flag_z;
          state_d = ST_FADDR;
        end
      end
      ST_EMEM: begin
        mem_req = 1'b1;
        mem_we  = (opcode == OP_W'(OPC_STORE));
        if (mem_ack) begin
          ctl.acc_load = (opcode == OP_W'(OPC_LOAD));
          ctl.acc_add  = (opcode == OP_W'(OPC_ADD));
          state_d      = ST_FADDR;
        end
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FADDR;
    else        state <= state_d;
  end

  assign halted = (state == ST_HALT);

  p_halt_park_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !mem_req);

  p_write_only_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state == ST_EMEM) && (opcode == OP_W'(OPC_STORE)));

  p_fetch_then_ir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FREAD) && mem_ack |=> ctl.ir_load);

endmodule

// File: rtl/cyc_sequencer.sv
module cyc_sequencer
  import cyc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_req,
  output logic              mem_we,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted,
  output logic [WORD_W-1:0] acc_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic              flag_z,
  output logic              flag_c
);

  localparam int OP_W   = WORD_W - ADDR_W - 1;
  localparam int IND_BIT = ADDR_W;

  cyc_ctl_t          ctl;
  logic [WORD_W-1:0] ir;
  logic [ADDR_W-1:0] mar;

  cyc_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (ir[WORD_W-1 -: OP_W]),
    .indirect (ir[IND_BIT]),
    .flag_z   (flag_z),
    .mem_ack  (mem_ack),
    .ctl      (ctl),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .halted   (halted)
  );

  cyc_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .rdata  (mem_rdata),
    .pc     (pc_out),
    .mar    (mar),
    .ir     (ir),
    .acc    (acc_out),
    .flag_z (flag_z),
    .flag_c (flag_c)
  );

  assign mem_addr  = mar;
  assign mem_wdata = acc_out;

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                            $stable(mem_wdata));

  p_write_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

endmodule

// File: tb/cyc_sequencer_test.sv
module cyc_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_req, mem_we;
  logic        mem_ack;
  logic [15:0] mem_rdata;
  logic        halted;
  logic [15:0] acc_out;
  logic [10:0] pc_out;
  logic        flag_z, flag_c;

  always #10 clk = ~clk;

  cyc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .halted(halted), .acc_out(acc_out), .pc_out(pc_out), .flag_z(flag_z),
    .flag_c(flag_c)
  );

  typedef struct { logic [10:0] a; logic [15:0] d; } wr_t;
  wr_t exp_q[$];

  logic [15:0] mem [0:2047];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int wait_cnt = 0;
  int lat = 0;
  logic first_req;
  logic park_req_seen;
  logic        prev_req;
  logic [10:0] prev_addr;
  logic        prev_we;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_write(input logic [10:0] a, input logic [15:0] d);
    wr_t w;
    w.a = a; w.d = d;
    exp_q.push_back(w);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [15:0] ins(input int op, input int ind, input int a);
    return 16'((op << 12) | (ind << 11) | a);
  endfunction

  // memory model, driver of ack, scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      wait_cnt = 0;
      prev_req = 1'b0;
    end else begin
      if (prev_req && mem_req && !mem_ack &&
          (mem_addr !== prev_addr || mem_we !== prev_we)) begin
        chk("R3 request changed before ack", {20'd0, mem_addr}, {20'd0, prev_addr});
      end
      prev_req  = mem_req && !mem_ack;
      prev_addr = mem_addr;
      prev_we   = mem_we;
      if (mem_ack) begin
        mem_ack = 1'b0;
        prev_req = 1'b0;
      end else if (mem_req) begin
        if (first_req) begin
          chk("R12 first request address", {20'd0, mem_addr}, 32'd0);
          chk("R12 first request is read", {31'd0, mem_we}, 32'd0);
          first_req = 1'b0;
        end
        if (halted) park_req_seen = 1'b1;
        if (wait_cnt >= lat) begin
          mem_ack   = 1'b1;
          mem_rdata = mem[mem_addr];
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            if (exp_q.size() == 0) begin
              chk("R6 unexpected write address", {20'd0, mem_addr}, 32'h7FF);
            end else begin
              wr_t w;
              w = exp_q.pop_front();
              chk("R6 write address", {20'd0, mem_addr}, {20'd0, w.a});
              chk("R6 write data", {16'd0, mem_wdata}, {16'd0, w.d});
            end
          end
          wait_cnt = 0;
          lat = (lat + 1) % 3;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic run_to_halt(input string tag);
    int n = 0;
    while (!halted && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, {31'd0, halted}, 32'd1);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
  endtask

  initial begin
    rst_n = 1'b0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    first_req = 1'b1;
    park_req_seen = 1'b0;
    clear_mem();
    // program 1: direct and indirect paths
    mem[0]  = ins(1, 0, 100);   // load 100
    mem[1]  = ins(3, 0, 101);   // add 101 -> 0, Z=1 C=1
    mem[2]  = ins(2, 0, 200);   // store 200
    mem[3]  = ins(5, 0, 6);     // jz 6 taken
    mem[4]  = ins(2, 0, 201);   // must be skipped
    mem[5]  = ins(0, 0, 0);
    mem[6]  = ins(1, 1, 102);   // load indirect -> 0x1234
    mem[7]  = ins(2, 1, 104);   // store indirect -> addr 300
    mem[8]  = ins(5, 0, 4);     // jz not taken
    mem[9]  = ins(7, 0, 0);     // no-op
    mem[10] = ins(4, 1, 105);   // jump indirect -> 12
    mem[11] = ins(2, 0, 201);   // must be skipped
    mem[12] = ins(3, 0, 106);   // add 1
    mem[13] = ins(2, 0, 202);
    mem[14] = ins(0, 0, 0);     // halt
    mem[100] = 16'h0005; mem[101] = 16'hFFFB; mem[102] = 16'd103;
    mem[103] = 16'h1234; mem[104] = 16'd300;  mem[105] = 16'd12;
    mem[106] = 16'h0001;
    expect_write(11'd200, 16'h0000);   // R7 add result zero, R9 jz taken next
    expect_write(11'd300, 16'h1234);   // R4 indirect load and store
    expect_write(11'd202, 16'h1235);
    repeat (3) @(negedge clk);
    chk("R12 reset pc", {21'd0, pc_out}, 32'd0);
    chk("R12 reset acc", {16'd0, acc_out}, 32'd0);
    chk("R12 reset flags", {30'd0, flag_z, flag_c}, 32'd0);
    chk("R12 no request in reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    run_to_halt("R11 program 1 halts");
    chk("R2 pc after halt fetch", {21'd0, pc_out}, 32'd15);
    chk("R7 acc after add", {16'd0, acc_out}, 32'h1235);
    chk("R7 flags after add", {30'd0, flag_z, flag_c}, 32'd0);
    chk("R8 R9 R10 pending writes done", exp_q.size(), 32'd0);
    chk("R9 skipped store left memory", {16'd0, mem[201]}, 32'd0);
    repeat (20) @(negedge clk);
    chk("R11 still halted", {31'd0, halted}, 32'd1);
    chk("R11 pc frozen", {21'd0, pc_out}, 32'd15);
    chk("R11 no request while parked", {31'd0, park_req_seen}, 32'd0);

    // program 2: carry paths, load clears carry
    rst_n = 1'b0;
    first_req = 1'b1;
    clear_mem();
    mem[0] = ins(1, 0, 100);   // load 0xFFFF
    mem[1] = ins(3, 0, 101);   // +2 -> 1, C=1
    mem[2] = ins(2, 0, 110);
    mem[3] = ins(5, 0, 0);     // jz not taken
    mem[4] = ins(1, 0, 103);   // load 0 -> Z=1 C=0
    mem[5] = ins(2, 0, 111);
    mem[6] = ins(3, 0, 104);   // +0x8000
    mem[7] = ins(3, 0, 104);   // +0x8000 -> 0, C=1 Z=1
    mem[8] = ins(2, 0, 112);
    mem[9] = ins(0, 1, 0);     // halt with indirect flag
    mem[100] = 16'hFFFF; mem[101] = 16'h0002; mem[103] = 16'h0000;
    mem[104] = 16'h8000;
    expect_write(11'd110, 16'h0001);   // R7 carry out
    expect_write(11'd111, 16'h0000);   // R5 load zero
    expect_write(11'd112, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R12 reset clears acc again", {16'd0, acc_out}, 32'd0);
    chk("R12 reset clears pc again", {21'd0, pc_out}, 32'd0);
    rst_n = 1'b1;
    run_to_halt("R11 program 2 halts");
    chk("R2 pc after second halt", {21'd0, pc_out}, 32'd10);
    chk("R7 acc after wrap", {16'd0, acc_out}, 32'd0);
    chk("R7 R9 zero and carry kept through store and halt", {30'd0, flag_z, flag_c}, 32'd3);
    chk("R5 R6 program 2 writes done", exp_q.size(), 32'd0);
    summary();
  end

endmodule